// File: doc/BRIEF.md
# Two-wire register access target

This block is a target on a two-wire (SMBus/I2C style) bus. It gives a host access to a small byte-wide register file that sits outside the block. The block sees SCL and SDA through two-flop synchronizers and runs on a system clock at least eight times faster than SCL. It finds START and STOP conditions and tracks when the bus falls idle. Its 7-bit address is a fixed 3-bit upper part joined with four strap inputs. The block pulls SDA low through an output-enable: the board's pull-up and the host's open drain form the wired-AND line.

Only two transactions are supported:
- A single-byte write: the device address with R/W=0, then the register address, then one data byte.
- A single-byte read: the device address with R/W=0 and the register address, then a repeated START, then the device address with R/W=1, after which the target shifts out one byte.

A write reaches the register-file port as a one-cycle strobe that carries the address and data. For a read, the register file answers combinationally with the addressed byte.

Top module: `smb_regslave`

## Requirements
- R1: A START is a falling SDA while SCL is high, and it restarts address reception from any state. A STOP is a rising SDA while SCL is high.
- R2: The target acknowledges its address only when the seven bits received MSB first equal {DEV_ID_HI, addr_strap_i}. On a mismatch it gives no ACK, commits no write, and ignores SCL until the next START or STOP.
- R3: In a write, after the data byte is acknowledged and the ninth SCL falls, reg_we_o pulses for exactly one cycle. During that pulse reg_addr_o holds the register-address byte and reg_wdata_o holds the data byte.
- R4: In a read, the target latches reg_rdata_i when it acknowledges the device address with R/W=1. It drives that byte MSB first, one bit per SCL low phase, and then releases SDA for the host's ACK/NACK bit.
- R5: The target gives an ACK by pulling SDA low (sda_oe_o=1) for the ninth clock of each byte it accepts. It asserts sda_oe_o only while SCL is low.
- R6: A START or STOP in the middle of a byte aborts the transaction, and no register write is made.
- R7: After a STOP, bus_idle_o rises once SCL and SDA have both stayed high for BUS_FREE_CYC system cycles.
- R8: Without a STOP, bus_idle_o rises once both lines have stayed high for HIGH_MAX_CYC cycles. The transaction is then dropped, and later bits are ignored until a START.
- R9: Only one data byte is taken per write. Further bytes before the STOP receive no ACK and cause no write.
- R10: After reset, sda_oe_o=0, reg_we_o=0 and bus_idle_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_strap_i | input | 4 | Low four bits of the target address |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| bus_idle_o | output | 1 | Bus is in the idle state |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
A wrong bit count or a wrong state shows up at the ports within one byte time, as a missing or misplaced ACK on the next ninth clock. A bad address compare shows up the same way. A misordered read shift corrupts the byte the host samples, and the bench checks it against its own register model. An early commit or an abort that is not honoured appears at once as an extra reg_we_o pulse. A wrong idle count is caught by sampling bus_idle_o both before and after its timeout.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_REGADDR,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int LINES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff        <= 2'b11;
        prev_o[g] <= 1'b1;
      end else begin
        ff        <= {ff[0], raw_i[g]};
        prev_o[g] <= ff[1];
      end
    end
    assign lvl_o[g] = ff[1];
  end
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int BUS_FREE_CYC = 64,
  parameter int HIGH_MAX_CYC = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic start_i,
  input  logic stop_i,
  output logic idle_o
);
  localparam int MAXC = (BUS_FREE_CYC > HIGH_MAX_CYC) ? BUS_FREE_CYC : HIGH_MAX_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          after_stop;
  logic          both_hi;

  assign both_hi = scl_i & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt        <= '0;
      after_stop <= 1'b0;
      idle_o     <= 1'b1;
    end else begin
      if (!both_hi)                cnt <= '0;
      else if (cnt != CW'(MAXC))   cnt <= cnt + 1'b1;

      if (stop_i)       after_stop <= 1'b1;
      else if (start_i) after_stop <= 1'b0;

      if (start_i || !both_hi)
        idle_o <= 1'b0;
      else if ((after_stop && cnt >= CW'(BUS_FREE_CYC)) || cnt >= CW'(HIGH_MAX_CYC))
        idle_o <= 1'b1;
    end
  end
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          idle_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o
);
  localparam int CNTW = $clog2(DW + 2);
  localparam logic [CNTW-1:0] BYTE_END = CNTW'(DW);
  localparam logic [CNTW-1:0] ACK_END  = CNTW'(DW + 1);

  smb_state_e    state;
  logic [CNTW-1:0] bit_cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] rd_sh;
  logic          match;

  assign match = (sh[DW-1 -: AW] == dev_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      sh          <= '0;
      rd_sh       <= '0;
      sda_oe_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      if (start_i) begin
        state    <= ST_DEVADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IGNORE;
        sda_oe_o <= 1'b0;
      end else if (idle_i && state != ST_IDLE) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
            if (scl_rise_i && bit_cnt < BYTE_END) begin
              sh      <= {sh[DW-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == BYTE_END) begin
              if (state != ST_DEVADDR || match) begin
                sda_oe_o <= 1'b1;
                bit_cnt  <= ACK_END;
                if (state == ST_DEVADDR && sh[0]) rd_sh <= reg_rdata_i;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (scl_fall_i && bit_cnt == ACK_END) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
              unique case (state)
                ST_DEVADDR: begin
                  if (sh[0]) begin
                    state    <= ST_RDATA;
                    sda_oe_o <= ~rd_sh[DW-1];
                  end else begin
                    state <= ST_REGADDR;
                  end
                end
                ST_REGADDR: begin
                  reg_addr_o <= sh;
                  state      <= ST_WDATA;
                end
                default: begin
                  reg_wdata_o <= sh;
                  reg_we_o    <= 1'b1;
                  state       <= ST_IGNORE;
                end
              endcase
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              if (bit_cnt == BYTE_END) state <= ST_IGNORE;
              else                     bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt == BYTE_END) begin
                sda_oe_o <= 1'b0;
              end else if (bit_cnt != '0) begin
                rd_sh    <= {rd_sh[DW-2:0], 1'b0};
                sda_oe_o <= ~rd_sh[DW-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [2:0] DEV_ID_HI    = 3'b101,
  parameter int         BUS_FREE_CYC = 64,
  parameter int         HIGH_MAX_CYC = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [3:0] addr_strap_i,
  output logic       sda_oe_o,
  output logic       bus_idle_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i
);
  logic [1:0] lvl, prev;
  logic scl_q, sda_q, scl_d, sda_d;
  logic start, stop, scl_rise, scl_fall;

  smb_sync #(.LINES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({scl_i, sda_i}),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  assign {scl_q, sda_q} = lvl;
  assign {scl_d, sda_d} = prev;
  assign start    = scl_q & scl_d &  sda_d & ~sda_q;
  assign stop     = scl_q & scl_d & ~sda_d &  sda_q;
  assign scl_rise =  scl_q & ~scl_d;
  assign scl_fall = ~scl_q &  scl_d;

  smb_idle_timer #(
    .BUS_FREE_CYC(BUS_FREE_CYC),
    .HIGH_MAX_CYC(HIGH_MAX_CYC)
  ) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_q),
    .sda_i  (sda_q),
    .start_i(start),
    .stop_i (stop),
    .idle_o (bus_idle_o)
  );

  smb_proto #(.AW(7), .DW(8)) u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_q),
    .start_i    (start),
    .stop_i     (stop),
    .idle_i     (bus_idle_o),
    .dev_addr_i ({DEV_ID_HI, addr_strap_i}),
    .reg_rdata_i(reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o)
  );
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic bus_idle_o
);
  a_r3_we_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r5_oe_rises_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  a_r8_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_o |-> !sda_oe_o);

  a_r7_no_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !bus_idle_o);
endmodule

bind smb_regslave smb_regslave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_q),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .bus_idle_o(bus_idle_o)
);

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] DEV_HI = 3'b101;
  localparam int BUS_FREE = 40;
  localparam int HIGH_MAX = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [3:0] strap = 4'd0;
  logic sda_oe, bus_idle, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;

  int checks = 0, failures = 0, we_count = 0;
  logic [7:0] regs [256];
  logic [7:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line  = sda_h & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'h00;
    end else if (reg_we) begin
      regs[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  smb_regslave #(
    .DEV_ID_HI   (DEV_HI),
    .BUS_FREE_CYC(BUS_FREE),
    .HIGH_MAX_CYC(HIGH_MAX)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_h),
    .sda_i       (sda_line),
    .addr_strap_i(strap),
    .sda_oe_o    (sda_oe),
    .bus_idle_o  (bus_idle),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; wclk(4);
    scl_h = 1'b1; wclk(4);
    sda_h = 1'b0; wclk(4);
    scl_h = 1'b0; wclk(4);
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; wclk(4);
    scl_h = 1'b1; wclk(4);
    sda_h = 1'b1; wclk(4);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_h = b;    wclk(4);
    scl_h = 1'b1; wclk(4);
    s = sda_line; wclk(4);
    scl_h = 1'b0; wclk(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic host_bit, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(host_bit, s);
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start;
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(ra, acks[1]);
    send_byte(d, acks[0]);
    bus_stop;
    wclk(BUS_FREE + 20);
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] d,
                         output logic [2:0] acks);
    bus_start;
    send_byte({dev, 1'b0}, acks[2]);
    send_byte(ra, acks[1]);
    bus_start;
    send_byte({dev, 1'b1}, acks[0]);
    recv_byte(1'b1, d);
    bus_stop;
    wclk(BUS_FREE + 20);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [2:0] acks;
    logic [7:0] rd;
    logic a, s;
    int wc;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    // R10 reset state
    check(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);
    check(reg_we == 1'b0, "R10 reg_we after reset", reg_we, 0);
    check(bus_idle == 1'b1, "R10 bus_idle after reset", bus_idle, 1);

    // R1 R2 R3 R4 R5: sweep all strap values
    for (int st = 0; st < 16; st++) begin
      logic [7:0] ra, d;
      strap = 4'(st);
      wclk(4);
      ra = 8'(st * 16 + 3);
      d  = 8'(st * 37 + 5);
      wc = we_count;
      do_write({DEV_HI, 4'(st)}, ra, d, acks);
      exp_mem[ra] = d;
      check(acks == 3'b111, "R5 write acks", acks, 7);
      check(we_count == wc + 1, "R3 one write strobe", we_count, wc + 1);
      check(regs[ra] == d, "R3 written register", regs[ra], d);
      do_read({DEV_HI, 4'(st)}, ra, rd, acks);
      check(acks == 3'b111, "R1 read acks", acks, 7);
      check(rd == exp_mem[ra], "R4 read data", rd, exp_mem[ra]);
      // R2 mismatch on strap bits and on upper bits
      wc = we_count;
      do_write({DEV_HI, 4'(st) ^ 4'h1}, ra, ~d, acks);
      check(acks[2] == 1'b0, "R2 no ack strap mismatch", acks[2], 0);
      do_write({DEV_HI ^ 3'b001, 4'(st)}, ra, ~d, acks);
      check(acks[2] == 1'b0, "R2 no ack upper mismatch", acks[2], 0);
      check(we_count == wc, "R2 no write on mismatch", we_count, wc);
      do_read({DEV_HI, 4'(st)}, ra, rd, acks);
      check(rd == exp_mem[ra], "R2 register unchanged", rd, exp_mem[ra]);
    end

    // R4 read of a never-written register
    strap = 4'd9;
    wclk(4);
    do_read({DEV_HI, 4'd9}, 8'hF0, rd, acks);
    check(rd == 8'h00, "R4 unwritten register", rd, 0);

    // R9 extra byte after data byte
    wc = we_count;
    bus_start;
    send_byte({DEV_HI, 4'd9, 1'b0}, a);
    send_byte(8'h44, a);
    send_byte(8'hA5, a);
    send_byte(8'h5A, a);
    check(a == 1'b0, "R9 no ack on extra byte", a, 0);
    bus_stop;
    wclk(BUS_FREE + 20);
    exp_mem[8'h44] = 8'hA5;
    check(we_count == wc + 1, "R9 single write", we_count, wc + 1);
    check(regs[8'h44] == 8'hA5, "R9 first byte kept", regs[8'h44], 8'hA5);

    // R6 abort by STOP mid data byte
    wc = we_count;
    bus_start;
    send_byte({DEV_HI, 4'd9, 1'b0}, a);
    send_byte(8'h44, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop;
    wclk(BUS_FREE + 20);
    check(we_count == wc, "R6 stop abort no write", we_count, wc);
    // R6 abort by START mid data byte
    bus_start;
    send_byte({DEV_HI, 4'd9, 1'b0}, a);
    send_byte(8'h44, a);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
    bus_start;
    bus_stop;
    wclk(BUS_FREE + 20);
    check(we_count == wc, "R6 start abort no write", we_count, wc);
    do_read({DEV_HI, 4'd9}, 8'h44, rd, acks);
    check(rd == 8'hA5, "R6 register unchanged", rd, 8'hA5);

    // R7 bus-free idle after STOP
    bus_start;
    send_byte({DEV_HI, 4'd9, 1'b0}, a);
    bus_stop;
    wclk(16);
    check(bus_idle == 1'b0, "R7 not idle before bus free", bus_idle, 0);
    wclk(40);
    check(bus_idle == 1'b1, "R7 idle after bus free", bus_idle, 1);

    // R8 SCL-high timeout without STOP
    bus_start;
    send_byte({DEV_HI, 4'd9, 1'b0}, a);
    sda_h = 1'b1; wclk(4);
    scl_h = 1'b1; wclk(100);
    check(bus_idle == 1'b0, "R8 not idle before high max", bus_idle, 0);
    wclk(150);
    check(bus_idle == 1'b1, "R8 idle after high max", bus_idle, 1);
    scl_h = 1'b0; wclk(4);
    wc = we_count;
    send_byte(8'h44, a);
    check(a == 1'b0, "R8 no ack after timeout", a, 0);
    send_byte(8'h11, a);
    check(a == 1'b0, "R8 still ignored", a, 0);
    bus_stop;
    wclk(BUS_FREE + 20);
    check(we_count == wc, "R8 no write after timeout", we_count, wc);
    do_read({DEV_HI, 4'd9}, 8'h44, rd, acks);
    check(acks == 3'b111 && rd == 8'hA5, "R1 recovers after timeout", rd, 8'hA5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule